// File: doc/BRIEF.md
# Quad-DAC Parallel Bus Sequencer

This block is a clocked host-side controller for a four-channel, 12-bit DAC that sits on a strobe-timed parallel bus. It takes one request at a time: a 3-bit operation code, a 2-bit channel number and a 12-bit data word. It turns each request into a fixed sequence on the bus pins: chip select, read/write, two address bits, the shared load strobe, the converter reset strobe, and a 12-bit data bus with an output enable. For a read-back it captures the returned word, presents it on `rd_data` and pulses `done`. Every other operation also ends with a one-cycle `done` pulse.

Each minimum time on the bus is given in nanoseconds as a parameter. The block turns it into a cycle count at elaboration: it divides by the clock period, rounds up, and uses at least one cycle. The sequencer then counts those cycles. Because of this, the same RTL can be retargeted to another clock by changing one parameter. The figures below are for the default 4 ns clock.

Top module: `dacbus_seq`

## Requirements
- R1: After a cycle with `rst` high, `bus_cs_n`, `bus_ld_n`, `bus_rst_n` and `bus_rw` are 1, `bus_oe`, `busy` and `done` are 0, and `rd_data` is 0.
- R2: A write (`req_op`=0) holds `bus_rw` low, `bus_oe` high, `bus_addr`=`req_ch` and `bus_dout`=`req_data` for one cycle before `bus_cs_n` falls, through the whole low pulse, and for one cycle after it rises. The low pulse lasts ceil(50 ns / period) cycles (13). The channel code is the plain binary channel number, so channel 0 is 00 and channel 3 is 11.
- R3: A read-back (`req_op`=1) holds `bus_rw` high for ceil(10 ns / period) cycles (3) before `bus_cs_n` falls. It then holds `bus_cs_n` low for the larger of ceil(200 ns / period) and ceil(160 ns / period) cycles (50), with `bus_oe` low throughout.
- R4: The word on `bus_din` during the last cycle of the read pulse appears on `rd_data` in the cycle `done` is high, and stays there until the next read.
- R5: After a read pulse ends, `bus_oe` stays low and `busy` stays high for ceil(100 ns / period) cycles (25) before `done`.
- R6: A write-and-load (`req_op`=3) drives `bus_ld_n` low for ceil(70 ns / period) cycles (18) before `bus_cs_n` falls. It keeps it low through a 13-cycle select pulse, and for ceil(50 ns / period) cycles (13) after `bus_cs_n` rises.
- R7: A load-all (`req_op`=2) drives `bus_ld_n` low for ceil(50 ns / period) cycles (13) and never lowers `bus_cs_n`.
- R8: A reset pulse (`req_op`=4) drives `bus_rst_n` low for ceil(50 ns / period) cycles (13), with `bus_cs_n` and `bus_ld_n` high. Afterwards a read-back of any channel returns 0.
- R9: A request is accepted when `req_valid` is high, `busy` is low and `req_op` is 0 to 4; `busy` is then high from the next cycle. A request made while `busy` is high, or one with `req_op` 5 to 7, changes no pin and no stored value.
- R10: Each accepted request gives exactly one single-cycle `done` pulse, in a cycle where `busy` is low. A request held through that cycle is accepted in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 3 | Operation: 0 write, 1 read-back, 2 load-all, 3 write-and-load, 4 reset pulse |
| req_ch | input | 2 | Channel number |
| req_data | input | 12 | Write data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 12 | Last captured read-back word |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_rw | output | 1 | 1 read, 0 write |
| bus_addr | output | 2 | Channel address |
| bus_ld_n | output | 1 | Load strobe for all converter registers, active low |
| bus_rst_n | output | 1 | Converter reset strobe, active low |
| bus_dout | output | 12 | Data driven to the bus |
| bus_oe | output | 1 | Enable for `bus_dout` |
| bus_din | input | 12 | Data read from the bus |

## Verification
The completion pulse of one sequence can fall in the same cycle as the acceptance of the next request. The bench provokes this by holding a second request on `req_valid` for the whole of a running sequence. The design must ignore it while `busy` is high and take it in the `done` cycle. This is judged in three ways: `busy` must be high again in the cycle right after `done`, the scoreboard must see both sequences complete with their own strobe widths, and no stray pulse may appear.

// File: rtl/dacbus_pkg.sv
package dacbus_pkg;

  typedef enum logic [2:0] {
    OP_WRITE    = 3'd0,
    OP_READ     = 3'd1,
    OP_LOADALL  = 3'd2,
    OP_WRLOAD   = 3'd3,
    OP_RSTPULSE = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_PRE   = 2'd1,
    PH_PULSE = 2'd2,
    PH_POST  = 2'd3
  } phase_e;

  typedef struct packed {
    logic cs_n;
    logic rw;
    logic ld_n;
    logic rst_n;
    logic oe;
  } bus_ctl_t;

  localparam bus_ctl_t BUS_QUIET = '{cs_n: 1'b1, rw: 1'b1, ld_n: 1'b1, rst_n: 1'b1, oe: 1'b0};

  // nanoseconds to whole clock cycles, rounded up, never below one
  function automatic int unsigned ns_to_cycles(input int unsigned ns, input int unsigned period_ns);
    int unsigned c;
    c = (ns + period_ns - 1) / period_ns;
    if (c == 0) c = 1;
    return c;
  endfunction

endpackage

// File: rtl/dacbus_phase_len.sv
module dacbus_phase_len
  import dacbus_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 4,
  parameter int unsigned T_WCS_NS      = 50,
  parameter int unsigned T_RCS_NS      = 200,
  parameter int unsigned T_RWS_NS      = 10,
  parameter int unsigned T_RDV_NS      = 160,
  parameter int unsigned T_DZ_NS       = 100,
  parameter int unsigned T_LS_NS       = 70,
  parameter int unsigned T_LH_NS       = 50,
  parameter int unsigned T_LDW_NS      = 50,
  parameter int unsigned T_RSTW_NS     = 50,
  parameter int unsigned CNT_W         = 16
) (
  input  op_e              op,
  input  phase_e           phase,
  output logic [CNT_W-1:0] len_m1
);

  localparam int unsigned C_WCS  = ns_to_cycles(T_WCS_NS,  CLK_PERIOD_NS);
  localparam int unsigned C_RCS0 = ns_to_cycles(T_RCS_NS,  CLK_PERIOD_NS);
  localparam int unsigned C_RDV  = ns_to_cycles(T_RDV_NS,  CLK_PERIOD_NS);
  localparam int unsigned C_RCS  = (C_RCS0 > C_RDV) ? C_RCS0 : C_RDV;
  localparam int unsigned C_RWS  = ns_to_cycles(T_RWS_NS,  CLK_PERIOD_NS);
  localparam int unsigned C_DZ   = ns_to_cycles(T_DZ_NS,   CLK_PERIOD_NS);
  localparam int unsigned C_LS   = ns_to_cycles(T_LS_NS,   CLK_PERIOD_NS);
  localparam int unsigned C_LH   = ns_to_cycles(T_LH_NS,   CLK_PERIOD_NS);
  localparam int unsigned C_LDW  = ns_to_cycles(T_LDW_NS,  CLK_PERIOD_NS);
  localparam int unsigned C_RSTW = ns_to_cycles(T_RSTW_NS, CLK_PERIOD_NS);

  int unsigned n_cyc;

  always_comb begin
    n_cyc = 1;
    unique case (op)
      OP_WRITE: begin
        if (phase == PH_PULSE) n_cyc = C_WCS;
      end
      OP_READ: begin
        if (phase == PH_PRE)   n_cyc = C_RWS;
        if (phase == PH_PULSE) n_cyc = C_RCS;
        if (phase == PH_POST)  n_cyc = C_DZ;
      end
      OP_LOADALL: begin
        if (phase == PH_PULSE) n_cyc = C_LDW;
      end
      OP_WRLOAD: begin
        if (phase == PH_PRE)   n_cyc = C_LS;
        if (phase == PH_PULSE) n_cyc = C_WCS;
        if (phase == PH_POST)  n_cyc = C_LH;
      end
      OP_RSTPULSE: begin
        if (phase == PH_PULSE) n_cyc = C_RSTW;
      end
      default: n_cyc = 1;
    endcase
    len_m1 = CNT_W'(n_cyc - 1);
  end

endmodule

// File: rtl/dacbus_strobe_map.sv
module dacbus_strobe_map
  import dacbus_pkg::*;
(
  input  op_e      op,
  input  phase_e   phase,
  output bus_ctl_t ctl
);

  logic active;
  logic in_pulse;

  always_comb begin
    active   = (phase != PH_IDLE);
    in_pulse = (phase == PH_PULSE);
    ctl      = BUS_QUIET;
    if (active) begin
      unique case (op)
        OP_WRITE: begin
          ctl.rw   = 1'b0;
          ctl.oe   = 1'b1;
          ctl.cs_n = ~in_pulse;
        end
        OP_WRLOAD: begin
          ctl.rw   = 1'b0;
          ctl.oe   = 1'b1;
          ctl.ld_n = 1'b0;
          ctl.cs_n = ~in_pulse;
        end
        OP_READ: begin
          ctl.cs_n = ~in_pulse;
        end
        OP_LOADALL: begin
          ctl.ld_n = ~in_pulse;
        end
        OP_RSTPULSE: begin
          ctl.rst_n = ~in_pulse;
        end
        default: ctl = BUS_QUIET;
      endcase
    end
  end

endmodule

// File: rtl/dacbus_seq.sv
module dacbus_seq
  import dacbus_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 4,
  parameter int unsigned DATA_W        = 12,
  parameter int unsigned CH_W          = 2,
  parameter int unsigned T_WCS_NS      = 50,
  parameter int unsigned T_RCS_NS      = 200,
  parameter int unsigned T_RWS_NS      = 10,
  parameter int unsigned T_RDV_NS      = 160,
  parameter int unsigned T_DZ_NS       = 100,
  parameter int unsigned T_LS_NS       = 70,
  parameter int unsigned T_LH_NS       = 50,
  parameter int unsigned T_LDW_NS      = 50,
  parameter int unsigned T_RSTW_NS     = 50,
  parameter int unsigned CNT_W         = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [CH_W-1:0]   req_ch,
  input  logic [DATA_W-1:0] req_data,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic              bus_cs_n,
  output logic              bus_rw,
  output logic [CH_W-1:0]   bus_addr,
  output logic              bus_ld_n,
  output logic              bus_rst_n,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_oe,
  input  logic [DATA_W-1:0] bus_din
);

  phase_e            st_q, st_d;
  op_e               op_q, op_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CNT_W-1:0]  len_m1;
  logic              load_cnt;
  logic              done_d;
  logic              accept;
  logic              op_known;
  logic [CH_W-1:0]   ch_q;
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] rd_q;
  logic              done_q;
  bus_ctl_t          ctl_d, ctl_q;

  assign op_known = (req_op <= 3'd4);
  assign accept   = req_valid && (st_q == PH_IDLE) && op_known;

  // phase sequencing: every operation walks PRE -> PULSE -> POST
  always_comb begin
    st_d     = st_q;
    op_d     = op_q;
    cnt_d    = cnt_q;
    load_cnt = 1'b0;
    done_d   = 1'b0;
    unique case (st_q)
      PH_IDLE: begin
        if (accept) begin
          st_d     = PH_PRE;
          op_d     = op_e'(req_op);
          load_cnt = 1'b1;
        end
      end
      PH_PRE: begin
        if (cnt_q == '0) begin
          st_d     = PH_PULSE;
          load_cnt = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_PULSE: begin
        if (cnt_q == '0) begin
          st_d     = PH_POST;
          load_cnt = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_POST: begin
        if (cnt_q == '0) begin
          st_d   = PH_IDLE;
          done_d = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: st_d = PH_IDLE;
    endcase
    if (load_cnt) cnt_d = len_m1;
  end

  dacbus_phase_len #(
    .CLK_PERIOD_NS(CLK_PERIOD_NS),
    .T_WCS_NS     (T_WCS_NS),
    .T_RCS_NS     (T_RCS_NS),
    .T_RWS_NS     (T_RWS_NS),
    .T_RDV_NS     (T_RDV_NS),
    .T_DZ_NS      (T_DZ_NS),
    .T_LS_NS      (T_LS_NS),
    .T_LH_NS      (T_LH_NS),
    .T_LDW_NS     (T_LDW_NS),
    .T_RSTW_NS    (T_RSTW_NS),
    .CNT_W        (CNT_W)
  ) u_len (
    .op    (op_d),
    .phase (st_d),
    .len_m1(len_m1)
  );

  // strobes come from the next phase so the pins are registered with it
  dacbus_strobe_map u_map (
    .op   (op_d),
    .phase(st_d),
    .ctl  (ctl_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= PH_IDLE;
      op_q   <= OP_WRITE;
      cnt_q  <= '0;
      ctl_q  <= BUS_QUIET;
      done_q <= 1'b0;
      ch_q   <= '0;
      data_q <= '0;
      rd_q   <= '0;
    end else begin
      st_q   <= st_d;
      op_q   <= op_d;
      cnt_q  <= cnt_d;
      ctl_q  <= ctl_d;
      done_q <= done_d;
      if (accept) begin
        ch_q   <= req_ch;
        data_q <= req_data;
      end
      // capture on the final cycle of the read strobe
      if (st_q == PH_PULSE && op_q == OP_READ && cnt_q == '0) begin
        rd_q <= bus_din;
      end
    end
  end

  assign busy      = (st_q != PH_IDLE);
  assign done      = done_q;
  assign rd_data   = rd_q;
  assign bus_cs_n  = ctl_q.cs_n;
  assign bus_rw    = ctl_q.rw;
  assign bus_ld_n  = ctl_q.ld_n;
  assign bus_rst_n = ctl_q.rst_n;
  assign bus_oe    = ctl_q.oe;
  assign bus_addr  = ch_q;
  assign bus_dout  = data_q;

endmodule

// File: rtl/dacbus_seq_chk.sv
module dacbus_seq_chk #(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned CH_W   = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [2:0]        req_op,
  input logic              busy,
  input logic              done,
  input logic              bus_cs_n,
  input logic              bus_rw,
  input logic [CH_W-1:0]   bus_addr,
  input logic              bus_ld_n,
  input logic              bus_rst_n,
  input logic [DATA_W-1:0] bus_dout,
  input logic              bus_oe
);

  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (bus_cs_n && bus_ld_n && bus_rst_n && bus_rw && !bus_oe && !busy && !done));

  a_r2_bus_steady_in_strobe: assert property (@(posedge clk) disable iff (rst)
    (!bus_cs_n && $past(!bus_cs_n)) |->
      ($stable(bus_addr) && $stable(bus_dout) && $stable(bus_rw) && $stable(bus_oe)));

  a_r2_setup_before_select: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_cs_n) |-> ($stable(bus_addr) && $stable(bus_rw) && $stable(bus_oe)));

  a_r3_read_not_driven: assert property (@(posedge clk) disable iff (rst)
    (!bus_cs_n && bus_rw) |-> !bus_oe);

  a_r5_release_after_read: assert property (@(posedge clk) disable iff (rst)
    ($rose(bus_cs_n) && bus_rw) |=> !bus_oe);

  a_r6_load_spans_select_edge: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_cs_n) |-> $stable(bus_ld_n));

  a_r8_reset_alone: assert property (@(posedge clk) disable iff (rst)
    !bus_rst_n |-> (bus_cs_n && bus_ld_n));

  a_r9_accept_when_idle: assert property (@(posedge clk) disable iff (rst)
    (!busy && req_valid && (req_op <= 3'd4)) |=> busy);

  a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r10_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

endmodule

bind dacbus_seq dacbus_seq_chk #(.DATA_W(DATA_W), .CH_W(CH_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .req_valid(req_valid),
  .req_op   (req_op),
  .busy     (busy),
  .done     (done),
  .bus_cs_n (bus_cs_n),
  .bus_rw   (bus_rw),
  .bus_addr (bus_addr),
  .bus_ld_n (bus_ld_n),
  .bus_rst_n(bus_rst_n),
  .bus_dout (bus_dout),
  .bus_oe   (bus_oe)
);

// File: tb/dacbus_seq_tb_top.sv
`timescale 1ns/1ps
module dacbus_seq_tb_top;

  localparam int PER = 4;

  function automatic int cyc(input int ns);
    int c;
    c = (ns + PER - 1) / PER;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int E_WCS  = cyc(50);
  localparam int E_RDV  = cyc(160);
  localparam int E_RCS  = (cyc(200) > E_RDV) ? cyc(200) : E_RDV;
  localparam int E_RWS  = cyc(10);
  localparam int E_DZ   = cyc(100);
  localparam int E_LS   = cyc(70);
  localparam int E_LH   = cyc(50);
  localparam int E_LDW  = cyc(50);
  localparam int E_RSTW = cyc(50);

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [2:0]  req_op = '0;
  logic [1:0]  req_ch = '0;
  logic [11:0] req_data = '0;
  logic        busy, done;
  logic [11:0] rd_data;
  logic        bus_cs_n, bus_rw, bus_ld_n, bus_rst_n, bus_oe;
  logic [1:0]  bus_addr;
  logic [11:0] bus_dout;
  logic [11:0] bus_din = '0;

  always #(PER/2) clk = ~clk;

  dacbus_seq #(.CLK_PERIOD_NS(PER)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op), .req_ch(req_ch),
    .req_data(req_data), .busy(busy), .done(done), .rd_data(rd_data),
    .bus_cs_n(bus_cs_n), .bus_rw(bus_rw), .bus_addr(bus_addr), .bus_ld_n(bus_ld_n),
    .bus_rst_n(bus_rst_n), .bus_dout(bus_dout), .bus_oe(bus_oe), .bus_din(bus_din)
  );

  typedef struct {
    int op; int ch; int data;
    int cs; int ldpre; int ldpost; int ldtot; int rstl; int rwpre; int oetail; int rd;
  } exp_t;

  exp_t        sbq[$];
  int          n_chk = 0;
  int          n_fail = 0;
  logic [11:0] shadow[4];
  logic [11:0] dev[4];

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  // expected item built from the requirements and a shadow of written words
  function automatic exp_t mk(input int op, input int ch, input int data);
    exp_t e;
    e = '{op: op, ch: ch, data: data, cs: 0, ldpre: 0, ldpost: 0, ldtot: 0,
          rstl: 0, rwpre: 0, oetail: 0, rd: 0};
    case (op)
      0: begin e.cs = E_WCS; shadow[ch] = 12'(data); end
      1: begin e.cs = E_RCS; e.rwpre = E_RWS; e.oetail = E_DZ; e.rd = int'(shadow[ch]); end
      2: e.ldtot = E_LDW;
      3: begin
        e.cs = E_WCS; e.ldpre = E_LS; e.ldpost = E_LH; e.ldtot = E_LS + E_WCS + E_LH;
        shadow[ch] = 12'(data);
      end
      default: begin
        e.rstl = E_RSTW;
        for (int i = 0; i < 4; i++) shadow[i] = '0;
      end
    endcase
    return e;
  endfunction

  task automatic drive(input int op, input int ch, input int data);
    req_op = 3'(op); req_ch = 2'(ch); req_data = 12'(data); req_valid = 1'b1;
  endtask

  task automatic send(input int op, input int ch, input int data);
    @(negedge clk);
    while (busy) @(negedge clk);
    sbq.push_back(mk(op, ch, data));
    drive(op, ch, data);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy || sbq.size() != 0) @(negedge clk);
  endtask

  // monitor: bus device model, strobe measurement, scoreboard compare
  int  m_cs, m_ldpre, m_ldpost, m_ldtot, m_rst, m_rwpre, m_oetail, m_bad, rdcnt;
  bit  m_seen;

  initial begin
    for (int i = 0; i < 4; i++) begin dev[i] = '0; shadow[i] = '0; end
    m_cs = 0; m_ldpre = 0; m_ldpost = 0; m_ldtot = 0; m_rst = 0;
    m_rwpre = 0; m_oetail = 0; m_bad = 0; rdcnt = 0; m_seen = 0;
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (!bus_cs_n && !bus_rw) dev[bus_addr] = bus_dout;
      if (!bus_rst_n) for (int i = 0; i < 4; i++) dev[i] = '0;
      if (!bus_cs_n && bus_rw) begin
        rdcnt++;
        bus_din = (rdcnt >= E_RDV) ? dev[bus_addr] : (12'hBAD ^ 12'(rdcnt));
      end else begin
        rdcnt = 0;
        bus_din = '0;
      end
      if (busy) begin
        if (!bus_cs_n) begin
          m_cs++; m_seen = 1;
          if (sbq.size() != 0 && (sbq[0].op == 0 || sbq[0].op == 3) &&
              (bus_dout != 12'(sbq[0].data) || bus_addr != 2'(sbq[0].ch) || !bus_oe || bus_rw))
            m_bad++;
        end
        if (!bus_ld_n) begin
          m_ldtot++;
          if (!m_seen) m_ldpre++; else if (bus_cs_n) m_ldpost++;
        end
        if (!bus_rst_n) m_rst++;
        if (bus_cs_n && !m_seen && bus_rw) m_rwpre++;
        if (bus_cs_n && m_seen && !bus_oe) m_oetail++;
      end
      if (done) begin
        if (sbq.size() == 0) begin
          chk(0, "R10", "done with nothing pending", 1, 0);
        end else begin
          exp_t e;
          e = sbq.pop_front();
          if (e.op == 1) begin
            chk(m_cs == e.cs, "R3", "read strobe cycles", m_cs, e.cs);
            chk(m_rwpre == e.rwpre, "R3", "rw setup cycles", m_rwpre, e.rwpre);
            chk(int'(rd_data) == e.rd, "R4", "read word", int'(rd_data), e.rd);
            chk(m_oetail == e.oetail, "R5", "release cycles", m_oetail, e.oetail);
          end else if (e.op == 0) begin
            chk(m_cs == e.cs, "R2", "write strobe cycles", m_cs, e.cs);
            chk(m_bad == 0, "R2", "bus fields during strobe", m_bad, 0);
            chk(m_ldtot == 0, "R2", "load strobe cycles", m_ldtot, 0);
          end else if (e.op == 3) begin
            chk(m_cs == e.cs, "R6", "select cycles", m_cs, e.cs);
            chk(m_ldpre == e.ldpre, "R6", "load lead cycles", m_ldpre, e.ldpre);
            chk(m_ldpost == e.ldpost, "R6", "load trail cycles", m_ldpost, e.ldpost);
            chk(m_ldtot == e.ldtot, "R6", "load total cycles", m_ldtot, e.ldtot);
            chk(m_bad == 0, "R6", "bus fields during strobe", m_bad, 0);
          end else if (e.op == 2) begin
            chk(m_ldtot == e.ldtot, "R7", "load cycles", m_ldtot, e.ldtot);
            chk(m_cs == 0, "R7", "select cycles", m_cs, 0);
          end else begin
            chk(m_rst == e.rstl, "R8", "reset strobe cycles", m_rst, e.rstl);
            chk(m_cs == 0 && m_ldtot == 0, "R8", "other strobes", m_cs + m_ldtot, 0);
          end
          chk(!busy, "R10", "busy in done cycle", int'(busy), 0);
        end
        m_cs = 0; m_ldpre = 0; m_ldpost = 0; m_ldtot = 0; m_rst = 0;
        m_rwpre = 0; m_oetail = 0; m_bad = 0; m_seen = 0;
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : stimulus
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(bus_cs_n && bus_ld_n && bus_rst_n && bus_rw, "R1", "strobes idle", 0, 1);
    chk(!bus_oe && !busy && !done, "R1", "oe/busy/done low", int'(bus_oe | busy | done), 0);
    chk(rd_data == 12'h000, "R1", "rd_data", int'(rd_data), 0);

    send(0, 0, 12'h123);
    send(0, 3, 12'hFFF);
    send(1, 0, 0);
    send(1, 3, 0);
    send(2, 0, 0);
    send(3, 2, 12'h800);
    send(1, 2, 0);
    send(4, 0, 0);
    send(1, 3, 0);       // R8 zero after reset pulse
    wait_idle();

    // R9 requests during a busy write are ignored
    send(0, 1, 12'h5A5);
    repeat (3) @(negedge clk);
    chk(busy, "R9", "busy during write", int'(busy), 1);
    drive(4, 1, 12'h000);
    repeat (4) @(negedge clk);
    req_valid = 1'b0;
    send(1, 1, 0);
    wait_idle();
    chk(rd_data == 12'h5A5, "R9", "word survives ignored request", int'(rd_data), 12'h5A5);

    // R9 unknown operation codes are ignored
    @(negedge clk);
    drive(5, 0, 0);
    @(negedge clk);
    drive(7, 0, 0);
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 4; i++) begin
      chk(!busy && !done && bus_cs_n && bus_ld_n && bus_rst_n, "R9", "unknown op idle",
          int'(busy | done), 0);
      @(negedge clk);
    end

    // R10 request held through done is taken in the done cycle
    @(negedge clk);
    while (busy) @(negedge clk);
    sbq.push_back(mk(0, 2, 12'h0F0));
    drive(0, 2, 12'h0F0);
    @(negedge clk);
    sbq.push_back(mk(1, 2, 0));
    drive(1, 2, 0);
    while (!done) @(negedge clk);
    @(negedge clk);
    chk(busy, "R10", "busy right after done", int'(busy), 1);
    req_valid = 1'b0;
    wait_idle();

    chk(sbq.size() == 0, "R10", "pending items", sbq.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule